// File: doc/BRIEF.md
# Skewer Projection Extrema Array

This block is a linear systolic array of `P` processing elements that finds, for `P` direction vectors at once, which pixel of a multi-band image projects highest and which projects lowest. Each element keeps one direction vector of `N` signed band weights for the whole pass. Pixel samples enter one band per beat at element 0 and ripple down the chain, one register per element, so no sample is ever fanned out to every element. Each element multiplies each arriving sample by its own weight for that band and sums the products over the `N` bands. When the last band of a pixel arrives, the element compares the finished sum with its running extremes.

A pass has three phases. In the first, `P*N` weights are shifted in through a single port. In the second, pixels are streamed until the last band of the pixel that carries the end flag. In the third, a second chain of result nodes takes a snapshot of every element's extreme indices and shifts them out one record per handshake. Larger direction sets are handled by running more passes, with fresh weights loaded each time. A one-cycle pulse closes each pass, and the array is then ready for the next load.

Top module: `skew_extrema_array`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `skw_ready_o` is 1 and `pix_ready_o`, `out_valid_o` and `done_o` are 0.
- R2: A pass starts by accepting exactly `P*N` weights on `skw_valid_i`/`skw_ready_o`. The first `N` weights accepted are bands 0 to `N-1` of element `P-1`, the next `N` are those of element `P-2`, and so on down to element 0. `pix_ready_o` goes to 1 in the cycle after the last weight is accepted.
- R3: Samples are signed two's complement `DW` bits and weights are signed `SW` bits. Each element's projection of a pixel is the exact signed sum over all bands of sample times weight, with no overflow across `N` bands of full-scale values.
- R4: For each element, the record carries the index of the pixel with the largest projection and the index of the pixel with the smallest. When projections are equal, the lower pixel index is kept.
- R5: Extremes restart at the first pixel (index 0) of every pass, so earlier passes have no effect. A pass of a single pixel reports index 0 for both extremes.
- R6: Pixel indices count from 0 in arrival order, one index per `N` accepted beats. `pix_last_i` counts only on the beat that carries band `N-1`. On any other beat it is ignored.
- R7: After the beat that ends the pass is accepted, `pix_ready_o` is 0 in the next cycle and stays 0 until the next load completes. Pixel beats offered outside the streaming phase, and weights offered outside the load phase, are ignored.
- R8: Records come out on `out_valid_o`/`out_ready_i` in element order 0 to `P-1`. `out_skw_id_o` counts handshaked records from 0 after reset, so it equals pass number times `P` plus the element. A record held under back-pressure stays stable.
- R9: `done_o` is 1 for exactly one cycle, the cycle after the handshake of a pass's last record. In that cycle `skw_ready_o` is 1.
- R10: At most one of `skw_ready_o`, `pix_ready_o` and `out_valid_o` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| skw_valid_i | input | 1 | Weight beat offered |
| skw_ready_o | output | 1 | Weight beat accepted (load phase) |
| skw_data_i | input | SW | Signed weight value |
| pix_valid_i | input | 1 | Pixel band beat offered |
| pix_ready_o | output | 1 | Pixel beat accepted (streaming phase) |
| pix_data_i | input | DW | Signed band sample |
| pix_last_i | input | 1 | Marks the final band of the final pixel |
| out_valid_o | output | 1 | Result record available |
| out_ready_i | input | 1 | Result record taken |
| out_skw_id_o | output | SIDW | Running direction-vector number of the record |
| out_max_idx_o | output | IDXW | Pixel index of the largest projection |
| out_min_idx_o | output | IDXW | Pixel index of the smallest projection |
| done_o | output | 1 | One-cycle end-of-pass pulse |

## Verification
A wrong weight slot, a misaligned band index in the rippling beat, or an accumulator that is not cleared shows up in the very next pass's records as a wrong max or min index for the affected element. Because each element reports separately, the bench can tell which element failed. A fault in the tie or first-pixel rule shows only on patterns with equal projections or with a single pixel, which is why those are driven on purpose. A drain or collection-chain fault appears within `P` cycles of the end beat as a missing, repeated or out-of-order record, a wrong running id, or a misplaced `done_o` pulse.

// File: rtl/skp_pkg.sv
package skp_pkg;
  typedef enum logic [2:0] {
    PH_LOAD   = 3'd0,
    PH_STREAM = 3'd1,
    PH_DRAIN  = 3'd2,
    PH_CAPT   = 3'd3,
    PH_COLL   = 3'd4
  } phase_e;
endpackage

// File: rtl/skp_pe.sv
module skp_pe #(
  parameter int N    = 8,
  parameter int DW   = 12,
  parameter int SW   = 10,
  parameter int IDXW = 10,
  parameter int BW   = 3,
  parameter int ACCW = 25
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   skw_shift_i,
  input  logic signed [SW-1:0]   skw_in_i,
  output logic signed [SW-1:0]   skw_out_o,
  input  logic                   b_vld_i,
  input  logic                   b_end_i,
  input  logic [BW-1:0]          b_band_i,
  input  logic [IDXW-1:0]        b_idx_i,
  input  logic signed [DW-1:0]   b_dat_i,
  output logic                   b_vld_o,
  output logic                   b_end_o,
  output logic [BW-1:0]          b_band_o,
  output logic [IDXW-1:0]        b_idx_o,
  output logic signed [DW-1:0]   b_dat_o,
  output logic [IDXW-1:0]        max_idx_o,
  output logic [IDXW-1:0]        min_idx_o
);
  localparam int PW = DW + SW;

  logic signed [SW-1:0]   skw_q [N];
  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] prod_ext, acc_q, acc_nxt, max_q, min_q;
  logic                   last_band, first_pix;

  // weight shift chain: enters at top band, leaves from band 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < N; b++) skw_q[b] <= '0;
    end else if (skw_shift_i) begin
      for (int b = 0; b < N - 1; b++) skw_q[b] <= skw_q[b+1];
      skw_q[N-1] <= skw_in_i;
    end
  end
  assign skw_out_o = skw_q[0];

  assign prod      = b_dat_i * skw_q[b_band_i];
  assign prod_ext  = {{(ACCW-PW){prod[PW-1]}}, prod};
  assign acc_nxt   = (b_band_i == '0) ? prod_ext : acc_q + prod_ext;
  assign last_band = (b_band_i == BW'(N - 1));
  assign first_pix = (b_idx_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      max_q     <= '0;
      min_q     <= '0;
      max_idx_o <= '0;
      min_idx_o <= '0;
    end else if (b_vld_i) begin
      acc_q <= acc_nxt;
      if (last_band) begin
        // strict compares keep the earlier index on ties
        if (first_pix || (acc_nxt > max_q)) begin
          max_q     <= acc_nxt;
          max_idx_o <= b_idx_i;
        end
        if (first_pix || (acc_nxt < min_q)) begin
          min_q     <= acc_nxt;
          min_idx_o <= b_idx_i;
        end
      end
    end
  end

  // one register per element: pixel ripples, never broadcast
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_vld_o  <= 1'b0;
      b_end_o  <= 1'b0;
      b_band_o <= '0;
      b_idx_o  <= '0;
      b_dat_o  <= '0;
    end else begin
      b_vld_o  <= b_vld_i;
      b_end_o  <= b_end_i & b_vld_i;
      b_band_o <= b_band_i;
      b_idx_o  <= b_idx_i;
      b_dat_o  <= b_dat_i;
    end
  end
endmodule

// File: rtl/skp_res_node.sv
module skp_res_node #(
  parameter int IDXW = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            shift_i,
  input  logic [IDXW-1:0] own_max_i,
  input  logic [IDXW-1:0] own_min_i,
  input  logic [IDXW-1:0] nxt_max_i,
  input  logic [IDXW-1:0] nxt_min_i,
  output logic [IDXW-1:0] max_o,
  output logic [IDXW-1:0] min_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_o <= '0;
      min_o <= '0;
    end else if (load_i) begin
      max_o <= own_max_i;
      min_o <= own_min_i;
    end else if (shift_i) begin
      max_o <= nxt_max_i;
      min_o <= nxt_min_i;
    end
  end
endmodule

// File: rtl/skp_ctrl.sv
module skp_ctrl
  import skp_pkg::*;
#(
  parameter int P    = 4,
  parameter int N    = 8,
  parameter int IDXW = 10,
  parameter int SIDW = 12,
  parameter int BW   = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            skw_valid_i,
  input  logic            pix_valid_i,
  input  logic            pix_last_i,
  input  logic            out_ready_i,
  input  logic            tail_end_i,
  output logic            skw_ready_o,
  output logic            skw_shift_o,
  output logic            pix_ready_o,
  output logic            pix_take_o,
  output logic [BW-1:0]   band_o,
  output logic [IDXW-1:0] idx_o,
  output logic            end_o,
  output logic            cap_o,
  output logic            shift_o,
  output logic            out_valid_o,
  output logic [SIDW-1:0] sid_o,
  output logic            done_o
);
  localparam int LDN = P * N;
  localparam int LDW = $clog2(LDN + 1);
  localparam int CW  = $clog2(P + 1);

  phase_e          ph_q;
  logic [LDW-1:0]  ld_q;
  logic [BW-1:0]   band_q;
  logic [IDXW-1:0] idx_q;
  logic [CW-1:0]   oc_q;
  logic [SIDW-1:0] sid_q;
  logic            done_q;

  assign skw_ready_o = (ph_q == PH_LOAD);
  assign pix_ready_o = (ph_q == PH_STREAM);
  assign out_valid_o = (ph_q == PH_COLL);
  assign cap_o       = (ph_q == PH_CAPT);
  assign skw_shift_o = skw_ready_o & skw_valid_i;
  assign pix_take_o  = pix_ready_o & pix_valid_i;
  assign shift_o     = out_valid_o & out_ready_i;
  assign band_o      = band_q;
  assign idx_o       = idx_q;
  assign end_o       = pix_last_i & (band_q == BW'(N - 1));
  assign sid_o       = sid_q;
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_LOAD;
      ld_q   <= '0;
      band_q <= '0;
      idx_q  <= '0;
      oc_q   <= '0;
      sid_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (ph_q)
        PH_LOAD: if (skw_shift_o) begin
          if (ld_q == LDW'(LDN - 1)) begin
            ld_q   <= '0;
            band_q <= '0;
            idx_q  <= '0;
            ph_q   <= PH_STREAM;
          end else begin
            ld_q <= ld_q + 1'b1;
          end
        end
        PH_STREAM: if (pix_take_o) begin
          if (band_q == BW'(N - 1)) begin
            band_q <= '0;
            idx_q  <= idx_q + 1'b1;
          end else begin
            band_q <= band_q + 1'b1;
          end
          if (end_o) ph_q <= PH_DRAIN;
        end
        PH_DRAIN: if (tail_end_i) ph_q <= PH_CAPT;
        PH_CAPT: begin
          oc_q <= '0;
          ph_q <= PH_COLL;
        end
        PH_COLL: if (shift_o) begin
          sid_q <= sid_q + 1'b1;
          if (oc_q == CW'(P - 1)) begin
            done_q <= 1'b1;
            ph_q   <= PH_LOAD;
          end else begin
            oc_q <= oc_q + 1'b1;
          end
        end
        default: ph_q <= PH_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/skew_extrema_array.sv
module skew_extrema_array #(
  parameter int P    = 4,
  parameter int N    = 8,
  parameter int DW   = 12,
  parameter int SW   = 10,
  parameter int IDXW = 10,
  parameter int SIDW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 skw_valid_i,
  output logic                 skw_ready_o,
  input  logic signed [SW-1:0] skw_data_i,
  input  logic                 pix_valid_i,
  output logic                 pix_ready_o,
  input  logic signed [DW-1:0] pix_data_i,
  input  logic                 pix_last_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [SIDW-1:0]      out_skw_id_o,
  output logic [IDXW-1:0]      out_max_idx_o,
  output logic [IDXW-1:0]      out_min_idx_o,
  output logic                 done_o
);
  localparam int BW   = (N > 1) ? $clog2(N) : 1;
  localparam int ACCW = DW + SW + BW;

  logic            skw_shift, pix_take, end_b, cap, shift;
  logic [BW-1:0]   band_c;
  logic [IDXW-1:0] idx_c;

  // beat chain: index e feeds element e
  logic                 c_vld  [P+1];
  logic                 c_end  [P+1];
  logic [BW-1:0]        c_band [P+1];
  logic [IDXW-1:0]      c_idx  [P+1];
  logic signed [DW-1:0] c_dat  [P+1];
  logic signed [SW-1:0] s_chain[P+1];
  logic [IDXW-1:0]      pe_max [P];
  logic [IDXW-1:0]      pe_min [P];
  logic [IDXW-1:0]      n_max  [P+1];
  logic [IDXW-1:0]      n_min  [P+1];

  skp_ctrl #(.P(P), .N(N), .IDXW(IDXW), .SIDW(SIDW), .BW(BW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .skw_valid_i (skw_valid_i),
    .pix_valid_i (pix_valid_i),
    .pix_last_i  (pix_last_i),
    .out_ready_i (out_ready_i),
    .tail_end_i  (c_vld[P-1] & c_end[P-1]),
    .skw_ready_o (skw_ready_o),
    .skw_shift_o (skw_shift),
    .pix_ready_o (pix_ready_o),
    .pix_take_o  (pix_take),
    .band_o      (band_c),
    .idx_o       (idx_c),
    .end_o       (end_b),
    .cap_o       (cap),
    .shift_o     (shift),
    .out_valid_o (out_valid_o),
    .sid_o       (out_skw_id_o),
    .done_o      (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_vld[0]  <= 1'b0;
      c_end[0]  <= 1'b0;
      c_band[0] <= '0;
      c_idx[0]  <= '0;
      c_dat[0]  <= '0;
    end else begin
      c_vld[0]  <= pix_take;
      c_end[0]  <= pix_take & end_b;
      c_band[0] <= band_c;
      c_idx[0]  <= idx_c;
      c_dat[0]  <= pix_data_i;
    end
  end

  assign s_chain[0] = skw_data_i;
  assign n_max[P]   = '0;
  assign n_min[P]   = '0;

  for (genvar e = 0; e < P; e++) begin : g_el
    skp_pe #(.N(N), .DW(DW), .SW(SW), .IDXW(IDXW), .BW(BW), .ACCW(ACCW)) u_pe (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .skw_shift_i (skw_shift),
      .skw_in_i    (s_chain[e]),
      .skw_out_o   (s_chain[e+1]),
      .b_vld_i     (c_vld[e]),
      .b_end_i     (c_end[e]),
      .b_band_i    (c_band[e]),
      .b_idx_i     (c_idx[e]),
      .b_dat_i     (c_dat[e]),
      .b_vld_o     (c_vld[e+1]),
      .b_end_o     (c_end[e+1]),
      .b_band_o    (c_band[e+1]),
      .b_idx_o     (c_idx[e+1]),
      .b_dat_o     (c_dat[e+1]),
      .max_idx_o   (pe_max[e]),
      .min_idx_o   (pe_min[e])
    );

    skp_res_node #(.IDXW(IDXW)) u_node (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (cap),
      .shift_i   (shift),
      .own_max_i (pe_max[e]),
      .own_min_i (pe_min[e]),
      .nxt_max_i (n_max[e+1]),
      .nxt_min_i (n_min[e+1]),
      .max_o     (n_max[e]),
      .min_o     (n_min[e])
    );
  end

  assign out_max_idx_o = n_max[0];
  assign out_min_idx_o = n_min[0];
endmodule

// File: rtl/skp_checker.sv
module skp_checker #(
  parameter int SIDW = 12,
  parameter int IDXW = 10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            skw_ready_o,
  input logic            pix_ready_o,
  input logic            out_valid_o,
  input logic            out_ready_i,
  input logic [SIDW-1:0] out_skw_id_o,
  input logic [IDXW-1:0] out_max_idx_o,
  input logic [IDXW-1:0] out_min_idx_o,
  input logic            done_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (skw_ready_o && !pix_ready_o && !out_valid_o && !done_o)
        else $error("reset state wrong");
    end
  end

  assert_phase_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({skw_ready_o, pix_ready_o, out_valid_o}));

  assert_rec_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_skw_id_o)
      && $stable(out_max_idx_o) && $stable(out_min_idx_o)));

  assert_id_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i) |=> (out_skw_id_o == $past(out_skw_id_o) + 1'b1));

  assert_done_after_hs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (skw_ready_o && $past(out_valid_o && out_ready_i)));

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_stream_to_drain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pix_ready_o) |-> !skw_ready_o);
endmodule

bind skew_extrema_array skp_checker #(.SIDW(SIDW), .IDXW(IDXW)) u_chk (.*);

// File: tb/skew_extrema_array_bench.sv
module skew_extrema_array_bench;
  localparam int P = 4, N = 8, DW = 12, SW = 10, IDXW = 10, SIDW = 12;
  localparam int MAXPIX = 48;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic                 skw_valid, skw_ready, pix_valid, pix_ready, pix_last;
  logic signed [SW-1:0] skw_data;
  logic signed [DW-1:0] pix_data;
  logic                 out_valid, out_ready, done;
  logic [SIDW-1:0]      out_id;
  logic [IDXW-1:0]      out_max, out_min;

  skew_extrema_array #(.P(P), .N(N), .DW(DW), .SW(SW), .IDXW(IDXW), .SIDW(SIDW))
    u_skew_extrema_array (
      .clk_i(clk), .rst_ni(rst_n),
      .skw_valid_i(skw_valid), .skw_ready_o(skw_ready), .skw_data_i(skw_data),
      .pix_valid_i(pix_valid), .pix_ready_o(pix_ready), .pix_data_i(pix_data),
      .pix_last_i(pix_last),
      .out_valid_o(out_valid), .out_ready_i(out_ready),
      .out_skw_id_o(out_id), .out_max_idx_o(out_max), .out_min_idx_o(out_min),
      .done_o(done));

  int n_chk = 0, n_err = 0;
  int sid_exp = 0;
  int skw [P][N];
  int pix [MAXPIX][N];
  bit finished = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd_s(int w);
    return int'($urandom_range(0, (1 << w) - 1)) - (1 << (w - 1));
  endfunction

  function automatic int dotp(int e, int p);
    int s = 0;
    for (int b = 0; b < N; b++) s += pix[p][b] * skw[e][b];
    return s;
  endfunction

  // R2: element P-1 first, bands ascending
  task automatic load_skewers(int mode);
    for (int e = 0; e < P; e++)
      for (int b = 0; b < N; b++)
        skw[e][b] = (mode == 1) ? -(1 << (SW - 1)) : rnd_s(SW);
    for (int e = P - 1; e >= 0; e--)
      for (int b = 0; b < N; b++) begin
        if ($urandom_range(0, 3) == 0) begin
          @(negedge clk); skw_valid = 1'b0;
        end
        @(negedge clk);
        skw_valid = 1'b1;
        skw_data  = skw[e][b][SW-1:0];
        while (!skw_ready) @(negedge clk);
      end
    @(negedge clk);
    skw_valid = 1'b0;
    chk(pix_ready == 1'b1, "R2 pix_ready after load", int'(pix_ready), 1);
  endtask

  task automatic stream(int np, bit noisy_last);
    for (int p = 0; p < np; p++)
      for (int b = 0; b < N; b++) begin
        if ($urandom_range(0, 4) == 0) begin
          @(negedge clk); pix_valid = 1'b0;
        end
        @(negedge clk);
        pix_valid = 1'b1;
        pix_data  = pix[p][b][DW-1:0];
        if (p == np - 1 && b == N - 1) pix_last = 1'b1;
        else if (noisy_last && b != N - 1) pix_last = 1'($urandom_range(0, 1)); // R6
        else pix_last = 1'b0;
        skw_valid = 1'b1;               // R7: ignored while streaming
        skw_data  = rnd_s(SW)[SW-1:0];
        while (!pix_ready) @(negedge clk);
      end
    @(negedge clk);
    skw_valid = 1'b0;
    chk(pix_ready == 1'b0, "R7 pix_ready drops after end", int'(pix_ready), 0);
    pix_valid = 1'b1;                   // R7: ignored while draining
    pix_data  = rnd_s(DW)[DW-1:0];
    pix_last  = 1'b1;
  endtask

  task automatic collect(int np, bit stall, string req);
    int k = 0;
    int mx [P];
    int mn [P];
    for (int e = 0; e < P; e++) begin
      int vmax = dotp(e, 0), vmin = dotp(e, 0);
      mx[e] = 0; mn[e] = 0;
      for (int p = 1; p < np; p++) begin
        int v = dotp(e, p);
        if (v > vmax) begin vmax = v; mx[e] = p; end
        if (v < vmin) begin vmin = v; mn[e] = p; end
      end
    end
    while (k < P) begin
      @(negedge clk);
      out_ready = stall ? 1'($urandom_range(0, 1)) : 1'b1;
      if (out_valid && out_ready) begin
        chk(int'(out_max) == mx[k], {req, " max idx"}, int'(out_max), mx[k]);
        chk(int'(out_min) == mn[k], {req, " min idx"}, int'(out_min), mn[k]);
        chk(int'(out_id) == (sid_exp % (1 << SIDW)), "R8 record id", int'(out_id), sid_exp);
        sid_exp++;
        k++;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk(done && skw_ready, "R9 done pulse with load ready", int'({done, skw_ready}), 3);
    pix_valid = 1'b0;
    pix_last  = 1'b0;
    @(negedge clk);
    chk(!done, "R9 done is one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(1357);
    rst_n = 1'b0; skw_valid = 0; skw_data = 0; pix_valid = 0; pix_data = 0;
    pix_last = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(skw_ready && !pix_ready && !out_valid && !done, "R1 reset state",
        int'({skw_ready, pix_ready, out_valid, done}), 8);

    // R3: random pass
    for (int p = 0; p < 20; p++) for (int b = 0; b < N; b++) pix[p][b] = rnd_s(DW);
    load_skewers(0); stream(20, 0); collect(20, 0, "R3 random");

    // R6 noisy last flags, R8 back-pressure
    for (int p = 0; p < 30; p++) for (int b = 0; b < N; b++) pix[p][b] = rnd_s(DW);
    load_skewers(0); stream(30, 1); collect(30, 1, "R6 noisy last");

    // R4: all projections equal
    for (int b = 0; b < N; b++) pix[0][b] = rnd_s(DW);
    for (int p = 1; p < 10; p++) for (int b = 0; b < N; b++) pix[p][b] = pix[0][b];
    load_skewers(0); stream(10, 0); collect(10, 1, "R4 ties");

    // R5: single pixel after a full pass
    for (int b = 0; b < N; b++) pix[0][b] = rnd_s(DW);
    load_skewers(0); stream(1, 0); collect(1, 0, "R5 single pixel");

    // R3: full-scale values
    for (int p = 0; p < 12; p++)
      for (int b = 0; b < N; b++) pix[p][b] = (p == 7) ? -(1 << (DW - 1)) : (1 << (DW - 1)) - 1;
    pix[3][2] = 0;
    load_skewers(1); stream(12, 0); collect(12, 0, "R3 full scale");

    // R4: duplicated extremes at later indices
    for (int p = 0; p < 16; p++) for (int b = 0; b < N; b++) pix[p][b] = rnd_s(DW);
    for (int b = 0; b < N; b++) begin pix[9][b] = pix[3][b]; pix[14][b] = pix[5][b]; end
    load_skewers(0); stream(16, 1); collect(16, 1, "R4 duplicates");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule